// File: doc/BRIEF.md
# CAN Transmit Mailbox Control and Status

This block owns the control and status byte of a single CAN transmit mailbox. It sits between a CPU register port and a transmit engine. Software arms the mailbox by writing a send bit. It may then ask for an abort. It reads back the outcome of the latest attempt, and it acknowledges completion by writing one to a done bit.

The engine sees a pending flag and an abort flag. For each attempt it returns a done pulse with a two-bit result code. It returns a separate acknowledge once an abort has taken effect. A failed attempt leaves the mailbox pending, so that the engine retries it.

While a request is pending, the mailbox's identifier and data byte registers are locked against CPU writes. The block turns each per-register write strobe into a write enable that passes only while the mailbox is empty. It also exports a one-cycle strobe on each successful send, which a shared status register can mirror.

Top module: `txmbx_ctrl`

## Requirements
- R1: After reset the control byte reads 00h, `eng_pend` is 0 and `mbx_empty` is 1.
- R2: Bits 7 and 6 of the control byte always read 0, and writes to them change nothing.
- R3: A write with bit 0 (send) set while the mailbox is empty sets send, and `eng_pend` follows on the next cycle. Writing 0 to bit 0 never clears it. Hardware clears send when the mailbox empties.
- R4: A write with bit 1 (abort) set takes effect only while send is set, and `eng_abort` then follows. While the mailbox is empty such a write has no effect. Hardware clears abort when the mailbox empties.
- R5: Bit 2 (done) is set after a successful attempt or an acknowledged abort. Writing 1 to bit 2 clears it, and so does a new request.
- R6: After each attempt, bits 3 (ok), 4 (lost) and 5 (fail) take the one-hot decode of the result code. Code 00 means success and sets ok. Code 01 means arbitration lost and sets lost. Codes 10 and 11 mean a transmission error and set fail. At most one of the three bits is ever set.
- R7: Clearing done, whether by a write of 1 or by a new request, also clears ok, lost and fail, unless an attempt completes in the same cycle.
- R8: If a hardware completion and a software write of 1 to bit 2 fall in the same cycle, done ends up set and the outcome bits show the new attempt.
- R9: After arbitration lost or an error, the mailbox stays pending. A success, or an abort acknowledge, empties it.
- R10: `mbx_empty` is the inverse of send. Each bit of `dreg_we` equals the matching bit of `dreg_wr` while the mailbox is empty, and is 0 otherwise.
- R11: `txok_pulse` is high for exactly the one cycle in which ok first reads 1 after a successful attempt.
- R12: `eng_done` and `eng_abort_ack` have no effect while the mailbox is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Write strobe for the control byte |
| csr_wdata | input | 8 | Write data: bit 0 set-send, bit 1 set-abort, bit 2 write-one-to-clear done |
| csr_rdata | output | 8 | Control byte {00, fail, lost, ok, done, abort, send} |
| eng_pend | output | 1 | Transmit request pending toward the engine |
| eng_abort | output | 1 | Abort requested toward the engine |
| eng_done | input | 1 | One attempt finished this cycle |
| eng_res | input | 2 | Attempt result: 00 ok, 01 arbitration lost, 1x error |
| eng_abort_ack | input | 1 | The abort has taken effect |
| mbx_empty | output | 1 | No request pending |
| txok_pulse | output | 1 | One-cycle strobe on a successful send |
| dreg_wr | input | DREG_N | CPU write strobes for the identifier and data registers |
| dreg_we | output | DREG_N | Gated write enables for those registers |

## Verification
The bench builds the block with DREG_N = 5. An odd lane count checks that every bit of the generated write gating follows the empty flag, not just a power-of-two slice. The result code width is fixed by the four outcomes. Within one short run the bench reaches each code, including the spare error code 11. It also reaches same-cycle collisions: completion against write-one-to-clear, abort against acknowledge, and engine events while idle.

// File: rtl/txmbx_pkg.sv
package txmbx_pkg;
  localparam int unsigned CSR_W  = 8;
  localparam int unsigned RES_W  = 2;
  localparam int unsigned B_SEND = 0;
  localparam int unsigned B_STOP = 1;
  localparam int unsigned B_DONE = 2;
  localparam int unsigned B_OK   = 3;
  localparam int unsigned B_LOST = 4;
  localparam int unsigned B_FAIL = 5;

  typedef enum logic [RES_W-1:0] {
    RES_OK   = 2'b00,
    RES_LOST = 2'b01,
    RES_FAIL = 2'b10,
    RES_FAIL_ALT = 2'b11
  } res_e;

  typedef struct packed {
    logic fail;
    logic lost;
    logic ok;
  } outc_t;
endpackage

// File: rtl/txmbx_req.sv
module txmbx_req (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_send,
  input  logic sw_stop,
  input  logic drop,
  output logic send_q,
  output logic stop_q,
  output logic new_req
);
  assign new_req = sw_send && !send_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_q <= 1'b0;
      stop_q <= 1'b0;
    end else if (drop) begin
      send_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (new_req) send_q <= 1'b1;
      if (sw_stop && send_q) stop_q <= 1'b1;
    end
  end

  AST_STOP_NEEDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> send_q); // R4
  AST_SEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (send_q && !drop) |=> send_q); // R9
endmodule

// File: rtl/txmbx_stat.sv
module txmbx_stat
  import txmbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  att_evt,
  input  res_e  att_res,
  input  logic  abt_evt,
  input  logic  sw_clr,
  input  logic  new_req,
  output logic  done_q,
  output outc_t outc_q,
  output logic  txok_pulse
);
  logic  good;
  logic  hw_set;
  logic  wipe;
  outc_t dec;

  assign good   = att_evt && (att_res == RES_OK);
  assign hw_set = good || abt_evt;
  assign wipe   = (sw_clr || new_req) && !hw_set;

  always_comb begin
    dec = '0;
    case (att_res)
      RES_OK:   dec.ok   = 1'b1;
      RES_LOST: dec.lost = 1'b1;
      default:  dec.fail = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      outc_q     <= '0;
      txok_pulse <= 1'b0;
    end else begin
      txok_pulse <= good;
      if (hw_set)                  done_q <= 1'b1;
      else if (sw_clr || new_req)  done_q <= 1'b0;
      if (att_evt)                 outc_q <= dec;
      else if (wipe)               outc_q <= '0;
    end
  end

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(outc_q)); // R6
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> done_q); // R8
  AST_PULSE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    txok_pulse |-> (outc_q.ok && done_q)); // R11
endmodule

// File: rtl/txmbx_wgate.sv
module txmbx_wgate #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open,
  input  logic [N-1:0] wr,
  output logic [N-1:0] we
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    assign we[i] = wr[i] & open;
  end

  AST_WE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (|we) |-> open); // R10
endmodule

// File: rtl/txmbx_ctrl.sv
module txmbx_ctrl
  import txmbx_pkg::*;
#(
  parameter int unsigned DREG_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic              eng_pend,
  output logic              eng_abort,
  input  logic              eng_done,
  input  logic [RES_W-1:0]  eng_res,
  input  logic              eng_abort_ack,
  output logic              mbx_empty,
  output logic              txok_pulse,
  input  logic [DREG_N-1:0] dreg_wr,
  output logic [DREG_N-1:0] dreg_we
);
  logic  send_q, stop_q, new_req, done_q;
  logic  att_evt, abt_evt, drop;
  res_e  res;
  outc_t outc;
  logic  unused_wbits;

  assign unused_wbits = ^{csr_wdata[CSR_W-1:B_FAIL+1], csr_wdata[B_FAIL:B_OK]};

  assign res     = res_e'(eng_res);
  assign att_evt = eng_done && send_q;
  assign abt_evt = eng_abort_ack && send_q;
  assign drop    = (att_evt && res == RES_OK) || abt_evt;

  txmbx_req u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_send (csr_wr && csr_wdata[B_SEND]),
    .sw_stop (csr_wr && csr_wdata[B_STOP]),
    .drop    (drop),
    .send_q  (send_q),
    .stop_q  (stop_q),
    .new_req (new_req)
  );

  txmbx_stat u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .att_evt    (att_evt),
    .att_res    (res),
    .abt_evt    (abt_evt),
    .sw_clr     (csr_wr && csr_wdata[B_DONE]),
    .new_req    (new_req),
    .done_q     (done_q),
    .outc_q     (outc),
    .txok_pulse (txok_pulse)
  );

  txmbx_wgate #(.N(DREG_N)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .open  (!send_q),
    .wr    (dreg_wr),
    .we    (dreg_we)
  );

  always_comb begin
    csr_rdata         = '0;
    csr_rdata[B_SEND] = send_q;
    csr_rdata[B_STOP] = stop_q;
    csr_rdata[B_DONE] = done_q;
    csr_rdata[B_OK]   = outc.ok;
    csr_rdata[B_LOST] = outc.lost;
    csr_rdata[B_FAIL] = outc.fail;
  end

  assign eng_pend  = send_q;
  assign eng_abort = stop_q;
  assign mbx_empty = !send_q;

  AST_IDLE_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_q && !csr_wr) |=> $stable(csr_rdata[B_FAIL:B_DONE])); // R12
endmodule

// File: tb/sim_txmbx_ctrl.sv
module sim_txmbx_ctrl;
  localparam int N = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_wr = 1'b0;
  logic [7:0] csr_wdata = '0, csr_rdata;
  logic eng_pend, eng_abort, mbx_empty, txok_pulse;
  logic eng_done = 1'b0, eng_abort_ack = 1'b0;
  logic [1:0] eng_res = '0;
  logic [N-1:0] dreg_wr = '0, dreg_we;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  txmbx_ctrl #(.DREG_N(N)) u0 (.*);

  // behavioural reference
  bit m_send, m_stop, m_done, m_ok, m_lost, m_fail, m_pulse;
  always @(posedge clk) begin
    if (!rst_n) begin
      {m_send, m_stop, m_done, m_ok, m_lost, m_fail, m_pulse} = '0;
    end else begin
      bit att, abt, succ, nreq, clr;
      att  = eng_done && m_send;
      abt  = eng_abort_ack && m_send;
      succ = att && eng_res == 2'd0;
      nreq = csr_wr && csr_wdata[0] && !m_send;
      clr  = csr_wr && csr_wdata[2];
      m_pulse = succ;
      if (att) begin
        m_ok = eng_res == 2'd0; m_lost = eng_res == 2'd1; m_fail = eng_res[1];
      end else if ((clr || nreq) && !(succ || abt)) begin
        m_ok = 0; m_lost = 0; m_fail = 0;
      end
      if (succ || abt) m_done = 1;
      else if (clr || nreq) m_done = 0;
      if (succ || abt) begin
        m_send = 0; m_stop = 0;
      end else begin
        if (csr_wr && csr_wdata[1] && m_send) m_stop = 1;
        if (nreq) m_send = 1;
      end
    end
  end

  function automatic logic [7:0] m_byte();
    return {2'b00, m_fail, m_lost, m_ok, m_done, m_stop, m_send};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("cycle rdata", csr_rdata, m_byte());
    chk("cycle pend", eng_pend, m_send);
    chk("cycle abort", eng_abort, m_stop);
    chk("cycle empty", mbx_empty, !m_send);
    chk("cycle pulse", txok_pulse, m_pulse);
    chk("cycle we", dreg_we, m_send ? '0 : dreg_wr);
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wr(logic [7:0] d);
    csr_wr = 1; csr_wdata = d; step(); csr_wr = 0; csr_wdata = 0;
  endtask
  task automatic att(logic [1:0] r);
    eng_done = 1; eng_res = r; step(); eng_done = 0; eng_res = 0;
  endtask
  task automatic look(); #5; endtask

  initial begin
    #400_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    look();
    chk("R1 reset byte", csr_rdata, 8'h00);
    chk("R1 reset pend", eng_pend, 1'b0);
    chk("R1 reset empty", mbx_empty, 1'b1);
    wr(8'hC0); look();
    chk("R2 reserved bits", csr_rdata, 8'h00);
    wr(8'h02); look();
    chk("R4 abort idle ignored", csr_rdata, 8'h00);
    dreg_wr = '1; #1;
    chk("R10 we open when empty", dreg_we, 5'h1F);
    dreg_wr = '0;
    wr(8'h01); look();
    chk("R3 send set", csr_rdata, 8'h01);
    chk("R3 pend", eng_pend, 1'b1);
    dreg_wr = 5'h15; #1;
    chk("R10 we locked when pending", dreg_we, 5'h00);
    dreg_wr = '0;
    wr(8'h00); look();
    chk("R3 write zero keeps send", csr_rdata, 8'h01);
    att(2'd1); look();
    chk("R9 lost keeps pending", csr_rdata, 8'h11);
    att(2'd0); look();
    chk("R5 success done ok", csr_rdata, 8'h0C);
    chk("R11 pulse", txok_pulse, 1'b1);
    step(); look();
    chk("R11 pulse one cycle", txok_pulse, 1'b0);
    wr(8'h04); look();
    chk("R7 w1c clears flags", csr_rdata, 8'h00);
    wr(8'h01); att(2'd2); look();
    chk("R6 error flag", csr_rdata, 8'h21);
    wr(8'h02); look();
    chk("R4 abort set", csr_rdata, 8'h23);
    eng_abort_ack = 1; step(); eng_abort_ack = 0; look();
    chk("R5 abort done", csr_rdata, 8'h24);
    wr(8'h01); look();
    chk("R7 new request clears", csr_rdata, 8'h01);
    csr_wr = 1; csr_wdata = 8'h04; eng_done = 1; eng_res = 2'd0;
    step(); csr_wr = 0; csr_wdata = 0; eng_done = 0; look();
    chk("R8 hardware wins", csr_rdata, 8'h0C);
    eng_done = 1; eng_res = 2'd1; eng_abort_ack = 1; step();
    eng_done = 0; eng_abort_ack = 0; look();
    chk("R12 idle events ignored", csr_rdata, 8'h0C);
    wr(8'h01); att(2'd3); look();
    chk("R6 code 11 is error", csr_rdata, 8'h21);
    eng_abort_ack = 1; step(); eng_abort_ack = 0;
    // pseudo-random phase, checked every cycle by the model
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        csr_wr        = lf[3:2] == 2'b00;
        csr_wdata     = {lf[11:8], lf[15:12]};
        eng_done      = lf[5:4] == 2'b01;
        eng_res       = lf[7:6];
        eng_abort_ack = lf[9:8] == 2'b11 && lf[0];
        dreg_wr       = lf[14:10];
        step();
      end
      csr_wr = 0; eng_done = 0; eng_abort_ack = 0; dreg_wr = 0;
    end
    step(); step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule